// File: doc/BRIEF.md
# Power-Path Supervisor with Filtered Comparators

This block is the digital half of a wireless-power receiver supervisor. Five raw comparator outputs arrive asynchronously: the coil zero-crossing detector, the wired-input over-voltage and under-voltage detectors, and the rectified-voltage over-voltage and under-voltage detectors. Each one passes through a two-stage synchronizer. A glitch filter follows, and each filter has its own hold count.

The filtered zero crossings feed a period meter. It reports the coil period in clock cycles. The filtered wired-input flags drive the enable for the wired-power switch, and a hold bit can keep that switch off. The filtered rectifier over-voltage flag drives the enable for the clamp driver. Every filtered status change, and every new period result, sets a sticky interrupt flag. Software clears a flag by writing 1 to it, and a per-flag mask gates the shared interrupt line.

Top module: `pwr_path_sup`

## Requirements
- R1: After reset, both under-voltage filtered flags read 1. Every other filtered flag, both enables, all sticky flags, the interrupt and the period-valid output read 0.
- R2: A change on a raw comparator input appears on its filtered output exactly N+3 clocks later. N is the channel's hold count, 0 to 255. The N+3 clocks are two synchronizer clocks plus N+1 consecutive samples at the new level.
- R3: A raw level that lasts fewer than N+1 samples leaves the filtered output unchanged.
- R4: The period output holds the number of clocks between the two most recent rising edges of the filtered zero crossing. This includes 500-clock periods. The count is 16 bits wide and saturates at all ones. The period-valid output goes to 1 after the second rising edge and stays at 1.
- R5: The wired switch enable goes to 1 one clock after both filtered wired flags are 0, provided the hold bit is 0. It goes to 0 one clock after either filtered wired flag is 1.
- R6: While the hold bit is 1, the wired switch enable is 0 from the next clock on, whatever the supply state.
- R7: The clamp enable follows the filtered rectifier over-voltage flag one clock later. It is released when that flag clears.
- R8: Sticky flag bit 0 records a change of the filtered wired OV flag, bit 1 wired UV, bit 2 rectifier OV, bit 3 rectifier UV and bit 4 a new period result. A bit sets one clock after its event, and the mask does not affect it.
- R9: Driving a 1 on a bit of the clear input for one clock clears that sticky bit at the next edge. A new event in the same clock takes priority over the clear.
- R10: The interrupt output is 1 whenever some sticky bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| zc_raw_i | input | 1 | Raw coil zero-crossing comparator |
| wovp_raw_i | input | 1 | Raw wired-input over-voltage comparator |
| wuvp_raw_i | input | 1 | Raw wired-input under-voltage comparator |
| rovp_raw_i | input | 1 | Raw rectifier over-voltage comparator |
| ruvp_raw_i | input | 1 | Raw rectifier under-voltage comparator |
| cfg_zc_dly_i | input | 8 | Hold count N, zero crossing |
| cfg_wovp_dly_i | input | 8 | Hold count N, wired OV |
| cfg_wuvp_dly_i | input | 8 | Hold count N, wired UV |
| cfg_rovp_dly_i | input | 8 | Hold count N, rectifier OV |
| cfg_ruvp_dly_i | input | 8 | Hold count N, rectifier UV |
| cfg_wsw_hold_i | input | 1 | Keeps the wired switch off |
| cfg_irq_mask_i | input | 5 | Interrupt mask, one bit per sticky flag |
| irq_clr_i | input | 5 | Write-1 clear of the sticky flags |
| zc_flt_o | output | 1 | Filtered zero crossing |
| wovp_flt_o | output | 1 | Filtered wired OV |
| wuvp_flt_o | output | 1 | Filtered wired UV |
| rovp_flt_o | output | 1 | Filtered rectifier OV |
| ruvp_flt_o | output | 1 | Filtered rectifier UV |
| period_o | output | 16 | Coil period in clocks |
| period_vld_o | output | 1 | Period output holds a result |
| wsw_en_o | output | 1 | Wired-power switch enable |
| clamp_en_o | output | 1 | Rectifier clamp enable |
| irq_flags_o | output | 5 | Sticky interrupt flags |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench builds the block with its default parameters. These are an 8-bit hold count, a 16-bit period counter and two synchronizer stages. With these values the timing is exact both at N=0 and at mid-range counts, and one pulse one sample too short shows the rejection edge. A 500-clock coil period, which is 500 kHz at the bench clock, fits well within the counter. Its period results are checked along with a shorter 50-clock period and a rejected zero-crossing glitch.

// File: rtl/pps_pkg.sv
package pps_pkg;

    localparam int FILT_W  = 8;
    localparam int PER_W   = 16;
    localparam int SYNC_N  = 2;
    localparam int NUM_CH  = 5;
    localparam int NUM_IRQ = 5;

    // channel slots in the filter bank
    localparam int CH_ZC  = 0;
    localparam int CH_WOV = 1;
    localparam int CH_WUV = 2;
    localparam int CH_ROV = 3;
    localparam int CH_RUV = 4;

    // under-voltage channels start asserted: no supply is assumed at reset
    localparam logic [NUM_CH-1:0] CH_RST_LVL = 5'b10100;

    // sticky flag positions
    localparam int IRQ_WOV = 0;
    localparam int IRQ_WUV = 1;
    localparam int IRQ_ROV = 2;
    localparam int IRQ_RUV = 3;
    localparam int IRQ_PER = 4;

    typedef struct packed {
        logic lvl;
        logic chg;
    } filt_out_t;

    function automatic logic [PER_W-1:0] sat_inc(input logic [PER_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/pps_glitch_filter.sv
module pps_glitch_filter
    import pps_pkg::*;
#(
    parameter int   DLY_W   = 8,
    parameter int   SYNC_ST = 2,
    parameter logic RST_LVL = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             raw_i,
    input  logic [DLY_W-1:0] dly_i,
    output filt_out_t        out_o
);

    logic [SYNC_ST-1:0] sync_q;
    logic               smp;
    logic [DLY_W-1:0]   cnt_q;
    logic               lvl_q;
    logic               chg_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= {SYNC_ST{RST_LVL}};
        else       sync_q <= {sync_q[SYNC_ST-2:0], raw_i};
    end

    assign smp = sync_q[SYNC_ST-1];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            lvl_q <= RST_LVL;
            chg_q <= 1'b0;
        end else begin
            chg_q <= 1'b0;
            if (smp == lvl_q) begin
                cnt_q <= '0;
            end else if (cnt_q >= dly_i) begin
                lvl_q <= smp;
                cnt_q <= '0;
                chg_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign out_o.lvl = lvl_q;
    assign out_o.chg = chg_q;

    // R2
    lvl_from_sample_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(smp)));

    // R8
    chg_marks_toggle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (lvl_q != $past(lvl_q)) |-> chg_q);

endmodule

// File: rtl/pps_period_meter.sv
module pps_period_meter
    import pps_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          zc_i,
    output logic [CW-1:0] period_o,
    output logic          vld_o,
    output logic          new_o
);

    logic          zc_d_q;
    logic          armed_q;
    logic [CW-1:0] cnt_q;
    logic          rise;

    assign rise = zc_i & ~zc_d_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            zc_d_q   <= 1'b0;
            armed_q  <= 1'b0;
            cnt_q    <= '0;
            period_o <= '0;
            vld_o    <= 1'b0;
            new_o    <= 1'b0;
        end else begin
            zc_d_q <= zc_i;
            new_o  <= 1'b0;
            if (rise) begin
                cnt_q   <= CW'(1);
                armed_q <= 1'b1;
                if (armed_q) begin
                    period_o <= cnt_q;
                    vld_o    <= 1'b1;
                    new_o    <= 1'b1;
                end
            end else begin
                cnt_q <= (&cnt_q) ? cnt_q : cnt_q + 1'b1;
            end
        end
    end

    // R4
    vld_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$fell(vld_o));

    // R4
    new_implies_vld_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        new_o |-> vld_o);

endmodule

// File: rtl/pps_irq_ctrl.sv
module pps_irq_ctrl #(
    parameter int N = 5
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] ev_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] flags_o,
    output logic         irq_o
);

    logic [N-1:0] flags_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) flags_q <= '0;
        else       flags_q <= (flags_q & ~clr_i) | ev_i;
    end

    assign flags_o = flags_q;
    assign irq_o   = |(flags_q & mask_i);

    // R9
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (($past(flags_q) & ~$past(clr_i) & ~flags_q) == '0));

    // R8
    flag_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (($past(ev_i) & ~flags_q) == '0));

endmodule

// File: rtl/pwr_path_sup.sv
module pwr_path_sup
    import pps_pkg::*;
#(
    parameter int DLY_W   = FILT_W,
    parameter int CNT_W   = PER_W,
    parameter int SYNC_ST = SYNC_N
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               zc_raw_i,
    input  logic               wovp_raw_i,
    input  logic               wuvp_raw_i,
    input  logic               rovp_raw_i,
    input  logic               ruvp_raw_i,
    input  logic [DLY_W-1:0]   cfg_zc_dly_i,
    input  logic [DLY_W-1:0]   cfg_wovp_dly_i,
    input  logic [DLY_W-1:0]   cfg_wuvp_dly_i,
    input  logic [DLY_W-1:0]   cfg_rovp_dly_i,
    input  logic [DLY_W-1:0]   cfg_ruvp_dly_i,
    input  logic               cfg_wsw_hold_i,
    input  logic [NUM_IRQ-1:0] cfg_irq_mask_i,
    input  logic [NUM_IRQ-1:0] irq_clr_i,
    output logic               zc_flt_o,
    output logic               wovp_flt_o,
    output logic               wuvp_flt_o,
    output logic               rovp_flt_o,
    output logic               ruvp_flt_o,
    output logic [CNT_W-1:0]   period_o,
    output logic               period_vld_o,
    output logic               wsw_en_o,
    output logic               clamp_en_o,
    output logic [NUM_IRQ-1:0] irq_flags_o,
    output logic               irq_o
);

    logic [NUM_CH-1:0] raw_vec;
    logic [DLY_W-1:0]  dly_arr [NUM_CH];
    filt_out_t         fo      [NUM_CH];
    logic              per_new;
    logic [NUM_IRQ-1:0] irq_ev;
    logic              wsw_q;
    logic              clamp_q;

    assign raw_vec[CH_ZC]  = zc_raw_i;
    assign raw_vec[CH_WOV] = wovp_raw_i;
    assign raw_vec[CH_WUV] = wuvp_raw_i;
    assign raw_vec[CH_ROV] = rovp_raw_i;
    assign raw_vec[CH_RUV] = ruvp_raw_i;

    assign dly_arr[CH_ZC]  = cfg_zc_dly_i;
    assign dly_arr[CH_WOV] = cfg_wovp_dly_i;
    assign dly_arr[CH_WUV] = cfg_wuvp_dly_i;
    assign dly_arr[CH_ROV] = cfg_rovp_dly_i;
    assign dly_arr[CH_RUV] = cfg_ruvp_dly_i;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_filt
        pps_glitch_filter #(
            .DLY_W  (DLY_W),
            .SYNC_ST(SYNC_ST),
            .RST_LVL(CH_RST_LVL[g])
        ) u_filt (
            .clk_i(clk_i),
            .rst_i(rst_i),
            .raw_i(raw_vec[g]),
            .dly_i(dly_arr[g]),
            .out_o(fo[g])
        );
    end

    pps_period_meter #(.CW(CNT_W)) u_per (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .zc_i    (fo[CH_ZC].lvl),
        .period_o(period_o),
        .vld_o   (period_vld_o),
        .new_o   (per_new)
    );

    assign irq_ev[IRQ_WOV] = fo[CH_WOV].chg;
    assign irq_ev[IRQ_WUV] = fo[CH_WUV].chg;
    assign irq_ev[IRQ_ROV] = fo[CH_ROV].chg;
    assign irq_ev[IRQ_RUV] = fo[CH_RUV].chg;
    assign irq_ev[IRQ_PER] = per_new;

    pps_irq_ctrl #(.N(NUM_IRQ)) u_irq (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .ev_i   (irq_ev),
        .clr_i  (irq_clr_i),
        .mask_i (cfg_irq_mask_i),
        .flags_o(irq_flags_o),
        .irq_o  (irq_o)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wsw_q   <= 1'b0;
            clamp_q <= 1'b0;
        end else begin
            wsw_q   <= ~fo[CH_WOV].lvl & ~fo[CH_WUV].lvl & ~cfg_wsw_hold_i;
            clamp_q <= fo[CH_ROV].lvl;
        end
    end

    assign zc_flt_o   = fo[CH_ZC].lvl;
    assign wovp_flt_o = fo[CH_WOV].lvl;
    assign wuvp_flt_o = fo[CH_WUV].lvl;
    assign rovp_flt_o = fo[CH_ROV].lvl;
    assign ruvp_flt_o = fo[CH_RUV].lvl;
    assign wsw_en_o   = wsw_q;
    assign clamp_en_o = clamp_q;

    // R5
    wsw_off_on_fault_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wovp_flt_o | wuvp_flt_o) |=> !wsw_en_o);

    // R6
    wsw_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cfg_wsw_hold_i |=> !wsw_en_o);

    // R7
    clamp_on_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rovp_flt_o |=> clamp_en_o);

    // R7
    clamp_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !rovp_flt_o |=> !clamp_en_o);

endmodule

// File: tb/pwr_path_sup_bench.sv
`timescale 1ns/1ps
module pwr_path_sup_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       zc = 1'b0, wovp = 1'b0, wuvp = 1'b1, rovp = 1'b0, ruvp = 1'b1;
    logic [7:0] d_zc = 8'd2, d_wov = 8'd5, d_wuv = 8'd2, d_rov = 8'd0, d_ruv = 8'd3;
    logic       hold = 1'b0;
    logic [4:0] mask = '0;
    logic [4:0] clr = '0;

    logic        zc_f, wov_f, wuv_f, rov_f, ruv_f, pvld, wsw, clamp, irq;
    logic [15:0] per;
    logic [4:0]  flags;

    always #2 clk = ~clk;

    pwr_path_sup u_pwr_path_sup (
        .clk_i(clk), .rst_i(rst),
        .zc_raw_i(zc), .wovp_raw_i(wovp), .wuvp_raw_i(wuvp),
        .rovp_raw_i(rovp), .ruvp_raw_i(ruvp),
        .cfg_zc_dly_i(d_zc), .cfg_wovp_dly_i(d_wov), .cfg_wuvp_dly_i(d_wuv),
        .cfg_rovp_dly_i(d_rov), .cfg_ruvp_dly_i(d_ruv),
        .cfg_wsw_hold_i(hold), .cfg_irq_mask_i(mask), .irq_clr_i(clr),
        .zc_flt_o(zc_f), .wovp_flt_o(wov_f), .wuvp_flt_o(wuv_f),
        .rovp_flt_o(rov_f), .ruvp_flt_o(ruv_f),
        .period_o(per), .period_vld_o(pvld),
        .wsw_en_o(wsw), .clamp_en_o(clamp),
        .irq_flags_o(flags), .irq_o(irq)
    );

    localparam int S_WOV = 0, S_WUV = 1, S_ROV = 2, S_RUV = 3, S_ZC = 4,
                   S_PER = 5, S_PVLD = 6, S_WSW = 7, S_CLAMP = 8,
                   S_FLAGS = 9, S_IRQ = 10;

    typedef struct {
        int due;
        int sel;
        int exp;
        int req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    function automatic int get_sig(input int sel);
        case (sel)
            S_WOV:   return int'(wov_f);
            S_WUV:   return int'(wuv_f);
            S_ROV:   return int'(rov_f);
            S_RUV:   return int'(ruv_f);
            S_ZC:    return int'(zc_f);
            S_PER:   return int'(per);
            S_PVLD:  return int'(pvld);
            S_WSW:   return int'(wsw);
            S_CLAMP: return int'(clamp);
            S_FLAGS: return int'(flags);
            default: return int'(irq);
        endcase
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops every expectation that falls due in this cycle
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == cyc) begin
                checks++;
                if (get_sig(q[i].sel) != q[i].exp) begin
                    errors++;
                    $display("FAIL R%0d sig=%0d cycle=%0d actual=%0d expected=%0d",
                             q[i].req, q[i].sel, cyc, get_sig(q[i].sel), q[i].exp);
                end
                q.delete(i);
            end
        end
    end

    // driver side: schedule an expectation dly cycles after now
    task automatic push(input int dly, input int sel, input int exp, input int req);
        exp_t e;
        e.due = cyc + dly;
        e.sel = sel;
        e.exp = exp;
        e.req = req;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        clr = 5'h1f;
        idle(1);
        clr = '0;
        idle(1);
    endtask

    task automatic zc_wave(input int half, input int cycles);
        for (int k = 0; k < cycles; k++) begin
            zc = 1'b1;
            idle(half);
            zc = 1'b0;
            idle(half);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst = 1'b0;
        // R1 reset state
        push(1, S_WUV, 1, 1);
        push(1, S_RUV, 1, 1);
        push(1, S_WOV, 0, 1);
        push(1, S_ROV, 0, 1);
        push(1, S_WSW, 0, 1);
        push(1, S_CLAMP, 0, 1);
        push(1, S_FLAGS, 0, 1);
        push(1, S_PVLD, 0, 1);
        push(1, S_IRQ, 0, 1);
        idle(4);

        // R2 filter latency with N=5 on the wired OV channel
        wovp = 1'b1;
        push(7, S_WOV, 0, 2);
        push(8, S_WOV, 1, 2);
        // R8 bit 0 set one clock after the filtered change
        push(8, S_FLAGS, 0, 8);
        push(9, S_FLAGS, 1, 8);
        idle(12);
        // R9 write-1 clear
        clr = 5'b00001;
        push(1, S_FLAGS, 0, 9);
        idle(1);
        clr = '0;
        idle(2);
        wovp = 1'b0;
        push(8, S_WOV, 0, 2);
        idle(12);

        // R3 rejection: ruvp N=3, a 3-sample pulse is ignored, 4 samples pass
        ruvp = 1'b0;
        idle(3);
        ruvp = 1'b1;
        push(1, S_RUV, 1, 3);
        push(4, S_RUV, 1, 3);
        push(8, S_RUV, 1, 3);
        idle(10);
        ruvp = 1'b0;
        push(6, S_RUV, 0, 2);
        push(9, S_RUV, 0, 2);
        idle(4);
        ruvp = 1'b1;
        push(6, S_RUV, 1, 2);
        push(5, S_RUV, 0, 2);
        idle(10);

        // R7 clamp with N=0 on the rectifier OV channel
        rovp = 1'b1;
        push(2, S_ROV, 0, 2);
        push(3, S_ROV, 1, 2);
        push(3, S_CLAMP, 0, 7);
        push(4, S_CLAMP, 1, 7);
        idle(8);
        rovp = 1'b0;
        push(3, S_CLAMP, 1, 7);
        push(4, S_CLAMP, 0, 7);
        idle(8);

        // R5 wired supply appears (UV clears, N=2)
        wuvp = 1'b0;
        push(5, S_WUV, 0, 2);
        push(5, S_WSW, 0, 5);
        push(6, S_WSW, 1, 5);
        idle(10);
        // R6 hold bit overrides
        hold = 1'b1;
        push(1, S_WSW, 0, 6);
        push(5, S_WSW, 0, 6);
        idle(6);
        hold = 1'b0;
        push(1, S_WSW, 1, 5);
        idle(4);
        // R5 over-voltage removes the switch
        wovp = 1'b1;
        push(8, S_WSW, 1, 5);
        push(9, S_WSW, 0, 5);
        idle(12);
        wovp = 1'b0;
        idle(14);

        // R10 masked interrupt
        clear_all();
        push(1, S_FLAGS, 0, 9);
        push(1, S_IRQ, 0, 10);
        idle(2);
        mask = 5'b00100;
        rovp = 1'b1;
        push(3, S_IRQ, 0, 10);
        push(4, S_IRQ, 1, 10);
        push(4, S_FLAGS, 5'b00100, 8);
        idle(6);
        mask = 5'b00011;
        push(1, S_IRQ, 0, 10);
        push(1, S_FLAGS, 5'b00100, 8);
        idle(2);
        rovp = 1'b0;
        idle(6);
        mask = '0;
        clear_all();

        // R4 period measurement, 50-clock period
        zc_wave(25, 4);
        push(1, S_PER, 50, 4);
        push(1, S_PVLD, 1, 4);
        push(1, S_FLAGS, 5'b10000, 8);
        idle(2);
        // R4 500-clock period (500 kHz at this clock)
        zc_wave(250, 3);
        push(1, S_PER, 500, 4);
        push(1, S_PVLD, 1, 4);
        idle(2);
        // R3 zero-crossing glitch (2 samples, N=2) rejected
        zc = 1'b1;
        idle(2);
        zc = 1'b0;
        push(1, S_ZC, 0, 3);
        push(3, S_ZC, 0, 3);
        push(8, S_PER, 500, 4);
        idle(12);

        while (q.size() != 0) idle(1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule